// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-side master of a two-wire management bus of the kind used to reach PHY registers. A single start pulse runs one clause-22 register read or write. The block generates the management clock from a programmable half-period divider. It drives the data line's output value and output enable, and it samples the line through a separate input. The tri-state pad sits outside the block.

Each transaction begins with a preamble of 32 ones. The block then shifts the command out most significant bit first. For a read it stops after 14 command bits, releases the line and collects 16 data bits from the PHY. For a write it sends the full 32-bit frame and then releases the line.

The line level is checked at three points. It must read high after the preamble. It must read low after the read turnaround clock. It must read high again on the released clock that ends the transaction. If any check fails, the block aborts at once, pulses `done` and raises `error`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `done` and `error` are 0 and `rdata` is 0.
- R2: Every bit slot is a low phase followed by a high phase on `mdc`. Each phase lasts `half_period`+1 clock cycles. Driven data changes only at the start of a low phase. The first 32 slots of every transaction drive `mdio_o`=1 with `mdio_oe`=1.
- R3: For a read (`rd_wr`=1), the preamble is followed by 14 driven bits, MSB first: start 01, opcode 10, `phy_addr`, `reg_addr`. Then comes one slot with `mdio_oe`=0.
- R4: For a write (`rd_wr`=0), the preamble is followed by 32 driven bits, MSB first: start 01, opcode 01, `phy_addr`, `reg_addr`, turnaround 10 and `wdata`. Then comes one slot with `mdio_oe`=0.
- R5: A read takes 16 bits with `mdio_oe`=0, MSB first. Each bit is sampled from `mdio_i` on the last cycle of its high phase. `rdata` takes the word only when the read completes without error, and it is otherwise unchanged.
- R6: If `mdio_i` is 0 when the last preamble bit is sampled, the transaction aborts with `error`=1. No command bit is sent.
- R7: If `mdio_i` is 1 when the read turnaround slot is sampled, the transaction aborts with `error`=1. No data bit is taken.
- R8: If `mdio_i` is 0 when the final released slot is sampled (read or write), `error` is set.
- R9: `done` is high for exactly one cycle at the end of every transaction, whether it passed or failed. At that cycle `mdc` and `mdio_oe` are low. `error` stays valid until the next accepted start.
- R10: A `start` while a transaction is running is ignored and does not change the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | HALF_W | Phase length minus one, in clock cycles |
| start | input | 1 | Start request, accepted only when idle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Last successfully read word |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Last transaction failed a line check |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line level |

## Verification
Most internal faults show up on `mdc`, `mdio_oe` or `mdio_o`, and they show up within one phase. A slot counter that is off by one shifts the point where the line is released, and the per-cycle comparison against the reference model catches it. A misloaded frame puts a wrong driven bit on the line in the slot where the error lies. A misplaced sample point or a wrong check polarity changes `done`, `error` or `rdata` at the end of the transaction; the bench makes the PHY respond correctly, stay silent and pull the line low in turn to expose each check.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = 32;
    localparam int RD_CMD_LEN = 14;
    localparam int DATA_LEN   = 16;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_CMD, ST_TA, ST_RD, ST_TAIL
    } mstate_e;

    typedef struct packed {
        mstate_e                st;
        logic [CNT_W-1:0]       bits;
        logic [FRAME_LEN-1:0]   sh;
        logic [FRAME_LEN-1:0]   cmd;
        logic [DATA_LEN-1:0]    rsh;
        logic [DATA_LEN-1:0]    rdata;
        logic                   done;
        logic                   err;
        logic                   isrd;
    } ctl_t;
endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_period,
    output logic              mdc,
    output logic              bit_end
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              hi;
    } tmr_t;

    tmr_t t_d, t_q;
    logic phase_end;

    assign phase_end = (t_q.cnt == half_period);
    assign mdc       = t_q.hi;
    assign bit_end   = run && t_q.hi && phase_end;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt = '0;
            t_d.hi  = 1'b0;
        end else if (phase_end) begin
            t_d.cnt = '0;
            t_d.hi  = !t_q.hi;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/mdio_frame_pack.sv
module mdio_frame_pack
    import mdio_pkg::*;
(
    input  logic                 rd,
    input  logic [4:0]           phy,
    input  logic [4:0]           regno,
    input  logic [DATA_LEN-1:0]  wdata,
    output logic [FRAME_LEN-1:0] frame
);
    always_comb begin
        if (rd) frame = {2'b01, 2'b10, phy, regno, 18'b0};
        else    frame = {2'b01, 2'b01, phy, regno, 2'b10, wdata};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   half_period,
    input  logic                start,
    input  logic                rd_wr,
    input  logic [4:0]          phy_addr,
    input  logic [4:0]          reg_addr,
    input  logic [15:0]         wdata,
    output logic [15:0]         rdata,
    output logic                done,
    output logic                error,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    ctl_t c_d, c_q;
    logic [FRAME_LEN-1:0] frame;
    logic run, bit_end;

    assign run = (c_q.st != ST_IDLE);

    mdio_phase_timer #(.HALF_W(HALF_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run), .half_period(half_period),
        .mdc(mdc), .bit_end(bit_end)
    );

    mdio_frame_pack u_pack (
        .rd(rd_wr), .phy(phy_addr), .regno(reg_addr), .wdata(wdata), .frame(frame)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (c_q.st == ST_IDLE) begin
            if (start) begin
                c_d.st   = ST_PRE;
                c_d.bits = CNT_W'(PRE_LEN - 1);
                c_d.sh   = '1;
                c_d.cmd  = frame;
                c_d.isrd = rd_wr;
                c_d.err  = 1'b0;
            end
        end else if (bit_end) begin
            case (c_q.st)
                ST_PRE: begin
                    if (c_q.bits == '0) begin
                        if (!mdio_i) begin
                            c_d.st = ST_IDLE; c_d.done = 1'b1; c_d.err = 1'b1;
                        end else begin
                            c_d.st   = ST_CMD;
                            c_d.sh   = c_q.cmd;
                            c_d.bits = c_q.isrd ? CNT_W'(RD_CMD_LEN - 1) : CNT_W'(FRAME_LEN - 1);
                        end
                    end else begin
                        c_d.sh   = {c_q.sh[FRAME_LEN-2:0], 1'b1};
                        c_d.bits = c_q.bits - 1'b1;
                    end
                end
                ST_CMD: begin
                    if (c_q.bits == '0) begin
                        c_d.st = c_q.isrd ? ST_TA : ST_TAIL;
                    end else begin
                        c_d.sh   = {c_q.sh[FRAME_LEN-2:0], 1'b0};
                        c_d.bits = c_q.bits - 1'b1;
                    end
                end
                ST_TA: begin
                    if (mdio_i) begin
                        c_d.st = ST_IDLE; c_d.done = 1'b1; c_d.err = 1'b1;
                    end else begin
                        c_d.st   = ST_RD;
                        c_d.bits = CNT_W'(DATA_LEN - 1);
                    end
                end
                ST_RD: begin
                    c_d.rsh = {c_q.rsh[DATA_LEN-2:0], mdio_i};
                    if (c_q.bits == '0) c_d.st = ST_TAIL;
                    else                c_d.bits = c_q.bits - 1'b1;
                end
                ST_TAIL: begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    if (!mdio_i)      c_d.err   = 1'b1;
                    else if (c_q.isrd) c_d.rdata = c_q.rsh;
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mdio_oe = (c_q.st == ST_PRE) || (c_q.st == ST_CMD);
    assign mdio_o  = mdio_oe && c_q.sh[FRAME_LEN-1];
    assign rdata   = c_q.rdata;
    assign done    = c_q.done;
    assign error   = c_q.err;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] rdata,
    input logic        done,
    input logic        error,
    input logic        mdc,
    input logic        mdio_oe
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdc && !mdio_oe));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && !error) |-> $stable(rdata));

    // R9
    error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> $stable(error));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rdata(rdata), .done(done),
    .error(error), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] half_period = 8'd1;
    logic start = 1'b0, rd_wr = 1'b0;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic done, error, mdc, mdio_o, mdio_oe, mdio_i;
    logic phy_lvl = 1'b1, force0 = 1'b0;

    always #10 clk = !clk;

    assign mdio_i = force0 ? 1'b0 : (mdio_oe ? mdio_o : phy_lvl);

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start),
        .rd_wr(rd_wr), .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .done(done), .error(error), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0, errors = 0;
    bit summary_done = 0;

    // reference model: slot list (drive flag, value, kind: 0 pre,1 cmd,2 ta,3 rd,4 tail)
    int s_drv[$], s_val[$], s_kind[$], s_phy[$];
    bit m_busy = 0, m_hi = 0, m_done = 0, m_err = 0, m_rd = 0;
    int m_tcnt = 0, m_si = 0, m_fault = 0;
    logic [15:0] m_rdata = '0, m_acc = '0, phy_word = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input int d, input int v, input int k, input int p);
        s_drv.push_back(d); s_val.push_back(v); s_kind.push_back(k); s_phy.push_back(p);
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            m_done = 0;
            if (m_busy) begin
                if (m_hi && m_tcnt == int'(half_period)) begin
                    m_hi = 0; m_tcnt = 0;
                    case (s_kind[m_si])
                        0: if (m_si == 31 && mdio_i == 1'b0) begin
                               m_busy = 0; m_done = 1; m_err = 1;
                           end
                        2: if (mdio_i == 1'b1) begin
                               m_busy = 0; m_done = 1; m_err = 1;
                           end
                        3: m_acc = {m_acc[14:0], mdio_i};
                        4: begin
                               m_busy = 0; m_done = 1;
                               if (mdio_i == 1'b0) m_err = 1;
                               else if (m_rd) m_rdata = m_acc;
                           end
                        default: ;
                    endcase
                    m_si++;
                end else if (m_tcnt == int'(half_period)) begin
                    m_tcnt = 0; m_hi = 1;
                end else m_tcnt++;
            end else if (start) begin
                s_drv.delete(); s_val.delete(); s_kind.delete(); s_phy.delete();
                for (int i = 0; i < 32; i++) push(1, 1, 0, 1);
                m_rd = rd_wr;
                if (rd_wr) begin
                    logic [13:0] c;
                    c = {2'b01, 2'b10, phy_addr, reg_addr};
                    for (int i = 13; i >= 0; i--) push(1, c[i], 1, 1);
                    push(0, 0, 2, (m_fault == 2) ? 1 : 0);
                    for (int i = 15; i >= 0; i--) push(0, 0, 3, phy_word[i]);
                end else begin
                    logic [31:0] c;
                    c = {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
                    for (int i = 31; i >= 0; i--) push(1, c[i], 1, 1);
                end
                push(0, 0, 4, (m_fault == 3) ? 0 : 1);
                m_busy = 1; m_hi = 0; m_tcnt = 0; m_si = 0; m_err = 0;
            end
        end
    end

    // bench PHY and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            force0  <= m_busy && m_fault == 1 && m_si < 32;
            phy_lvl <= m_busy ? s_phy[m_si][0] : 1'b1;
            begin
                int e_oe, e_o, e_mdc;
                e_mdc = m_busy ? int'(m_hi) : 0;
                e_oe  = m_busy ? s_drv[m_si] : 0;
                e_o   = m_busy ? s_val[m_si] : 0;
                chk(mdc == e_mdc[0], "R2 mdc", mdc, e_mdc);
                chk(mdio_oe == e_oe[0], "R3/R4 mdio_oe", mdio_oe, e_oe);
                if (e_oe != 0) chk(mdio_o == e_o[0], "R2/R3/R4 mdio_o", mdio_o, e_o);
                chk(done == m_done, "R9 done", done, m_done);
                chk(error == m_err, "R6/R7/R8 error", error, m_err);
                chk(rdata == m_rdata, "R5 rdata", rdata, m_rdata);
            end
        end
    end

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] val, input int fault, input int hp,
                           input bit poke_busy);
        @(negedge clk);
        half_period = 8'(hp);
        m_fault = fault;
        rd_wr = rd; phy_addr = pa; reg_addr = ra; wdata = val; phy_word = val;
        start = 1;
        @(negedge clk);
        start = 0;
        if (poke_busy) begin
            repeat (40) @(negedge clk);
            // R10: a second request with other fields while busy
            rd_wr = !rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~val; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mdc == 0 && mdio_oe == 0, "R1 bus idle", {mdc, mdio_oe}, 0);
        chk(done == 0 && error == 0, "R1 flags", {done, error}, 0);
        chk(rdata == 16'h0, "R1 rdata", rdata, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run_txn(1, 5'd5, 5'd2, 16'hA5C3, 0, 1, 0);
        chk(error == 0 && rdata == 16'hA5C3, "R5 read ok", rdata, 16'hA5C3);
        run_txn(0, 5'd17, 5'd9, 16'h1E0F, 0, 0, 0);
        chk(error == 0, "R4 write ok", error, 0);
        chk(rdata == 16'hA5C3, "R5 rdata kept on write", rdata, 16'hA5C3);
        run_txn(1, 5'd31, 5'd0, 16'h0001, 0, 2, 0);
        chk(rdata == 16'h0001, "R3 read h=2", rdata, 16'h0001);
        run_txn(1, 5'd3, 5'd7, 16'h8000, 1, 1, 0);
        chk(error == 1, "R6 preamble low", error, 1);
        chk(rdata == 16'h0001, "R6 rdata kept", rdata, 16'h0001);
        run_txn(1, 5'd3, 5'd7, 16'h7777, 2, 0, 0);
        chk(error == 1, "R7 no turnaround", error, 1);
        run_txn(1, 5'd9, 5'd4, 16'h5A5A, 3, 1, 0);
        chk(error == 1 && rdata == 16'h0001, "R8 read tail low", rdata, 16'h0001);
        run_txn(0, 5'd9, 5'd4, 16'h5A5A, 3, 0, 0);
        chk(error == 1, "R8 write tail low", error, 1);
        run_txn(1, 5'd12, 5'd21, 16'hC0DE, 0, 1, 1);
        chk(error == 0 && rdata == 16'hC0DE, "R10 busy start ignored", rdata, 16'hC0DE);
        repeat (5) @(negedge clk);
        chk(done == 0 && mdio_oe == 0 && mdc == 0, "R10 no extra transaction", {done, mdio_oe, mdc}, 0);

        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule